// File: doc/BRIEF.md
# Root-Clock Divider and Peripheral Gate Controller

This block sits beside a single root clock and derives three bus-domain rates from it: a processor rate, a main-interconnect rate and a peripheral-bus rate. Each rate is produced as a one-cycle clock-enable strobe in the root domain. Its ratio is a power of two, chosen by a 2-bit field in a shared divider register. A new ratio is held pending and is applied only at the end of an 8-cycle frame. At that point every divided output has just strobed, so no period is ever cut short.

The block also holds a clock-gate vector and a reset vector for 30 peripheral slots, with one bit of each per slot. A slot is reported as running only when its reset bit is clear and its gate bit is set. Software brings a slot up by clearing its reset bit and then opening its gate. It shuts a slot down by asserting reset and then closing the gate. Slots 0 and 23 leave reset already running, and slot 17 is unused. All registers sit on a 32-bit write/read bus whose read data is combinational from the address.

Top module: `clk_div_gate_ctrl`

## Requirements
- R1: After reset the divider register reads 0x00000010, the gate register reads 0x00800001, the reset register reads 0x3F7DFFFE, and run_o equals 0x00800001.
- R2: The divider register is at byte offset 0x08, with the processor field in bits [1:0], the interconnect field in bits [3:2] and the peripheral-bus field in bits [5:4]; bits [31:6] read as 0 and a read returns the last accepted setting.
- R3: A field value v makes its strobe pulse once in every 2^v root cycles (v=0 gives a strobe every cycle, v=3 gives one every 8 cycles).
- R4: A write carrying 0 in the peripeheral-bus field leaves that field at its previous value, while the other two fields of the same write are still accepted.
- R5: A new divider setting takes effect only at the end of the current 8-cycle frame; until then the old ratios continue, and in the last cycle of every frame all three strobes are high together.
- R6: The gate register is at byte offset 0x84 and the reset register at 0x88; bit n of each belongs to peripheral slot n and reads back as written.
- R7: Bit 17 and bits [31:30] of the gate and reset registers read as 0 and ignore writes.
- R8: run_o[n] is 1 exactly when reset bit n is 0 and gate bit n is 1.
- R9: Offsets other than 0x08, 0x84 and 0x88 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Root clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| cpu_ce | output | 1 | Processor-rate clock-enable strobe |
| axi_ce | output | 1 | Interconnect-rate clock-enable strobe |
| ahb_ce | output | 1 | Peripheral-bus-rate clock-enable strobe |
| gate_o | output | 30 | Per-slot clock-gate outputs |
| prst_o | output | 30 | Per-slot reset outputs, active high |
| run_o | output | 30 | Per-slot running status |

## Verification
The hazard this block must handle is a divider write that lands in the same cycle as the frame wrap, or in the middle of a frame while strobes are still running at the old ratio. The bench waits for a processor strobe at divide-by-8, which marks the last cycle of a frame, and writes divide-by-1 in the next cycle. It then requires exactly one strobe over the following eight cycles, followed by a strobe on every cycle. A second case is a register write whose zero peripheral-bus field must be dropped while its other fields take effect. That case is judged both by read-back and by counting strobes over 64 cycles.

// File: rtl/clk_div_gate_ctrl.sv
module clk_div_gate_ctrl #(
  parameter int NSLOT = 30,
  parameter logic [7:0] DIV_OFS = 8'h08,
  parameter logic [7:0] GATE_OFS = 8'h84,
  parameter logic [7:0] RST_OFS = 8'h88
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             cpu_ce,
  output logic             axi_ce,
  output logic             ahb_ce,
  output logic [NSLOT-1:0] gate_o,
  output logic [NSLOT-1:0] prst_o,
  output logic [NSLOT-1:0] run_o
);
  localparam logic [NSLOT-1:0] USED = ~(NSLOT'(1) << 17);
  localparam logic [NSLOT-1:0] CRIT = (NSLOT'(1) << 0) | (NSLOT'(1) << 23);
  localparam logic [5:0] DIV_RST = 6'h10;

  logic [2:0]       frame;
  logic [5:0]       div_pend, div_act;
  logic [NSLOT-1:0] gate_r, prst_r;

  function automatic logic tick(input logic [1:0] v, input logic [2:0] c);
    case (v)
      2'd0: tick = 1'b1;
      2'd1: tick = c[0];
      2'd2: tick = &c[1:0];
      default: tick = &c;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame    <= '0;
      div_pend <= DIV_RST;
      div_act  <= DIV_RST;
      gate_r   <= CRIT;
      prst_r   <= USED & ~CRIT;
    end else begin
      frame <= frame + 3'd1;
      if (frame == 3'd7) div_act <= div_pend;
      if (wr_en && addr == DIV_OFS) begin
        div_pend[3:0] <= wdata[3:0];
        if (wdata[5:4] != 2'd0) div_pend[5:4] <= wdata[5:4];
      end
      if (wr_en && addr == GATE_OFS) gate_r <= wdata[NSLOT-1:0] & USED;
      if (wr_en && addr == RST_OFS)  prst_r <= wdata[NSLOT-1:0] & USED;
    end
  end

  assign cpu_ce = tick(div_act[1:0], frame);
  assign axi_ce = tick(div_act[3:2], frame);
  assign ahb_ce = tick(div_act[5:4], frame);
  assign gate_o = gate_r;
  assign prst_o = prst_r;
  assign run_o  = gate_r & ~prst_r;

  always_comb begin
    rdata = '0;
    if (addr == DIV_OFS)       rdata[5:0] = div_pend;
    else if (addr == GATE_OFS) rdata[NSLOT-1:0] = gate_r;
    else if (addr == RST_OFS)  rdata[NSLOT-1:0] = prst_r;
  end

  assert_ahb_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_act[5:4] != 2'd0 && div_pend[5:4] != 2'd0);

  assert_zero_ahb_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DIV_OFS && wdata[5:4] == 2'd0) |=> $stable(div_pend[5:4]));

  assert_switch_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_act) |-> (frame == 3'd0 && $past(frame) == 3'd7));

  assert_frame_end_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame == 3'd7) |-> (cpu_ce && axi_ce && ahb_ce));

  assert_unused_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_o[17] && !prst_o[17] && !run_o[17]);
endmodule

// File: tb/clk_div_gate_ctrl_tb_top.sv
module clk_div_gate_ctrl_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        cpu_ce, axi_ce, ahb_ce;
  logic [29:0] gate_o, prst_o, run_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_div_gate_ctrl dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cpu_ce(cpu_ce), .axi_ce(axi_ce), .ahb_ce(ahb_ce),
    .gate_o(gate_o), .prst_o(prst_o), .run_o(run_o));

  // {write cfg[5:0], readback[5:0], cpu count, axi count, ahb count} over 64 cycles
  localparam int NV = 5;
  localparam logic [32:0] VEC [NV] = '{
    {6'h10, 6'h10, 7'd64, 7'd64, 7'd32},
    {6'h39, 6'h39, 7'd32, 7'd16, 7'd8},
    {6'h2E, 6'h2E, 7'd16, 7'd8,  7'd16},
    {6'h07, 6'h27, 7'd8,  7'd32, 7'd16},
    {6'h1B, 6'h1B, 7'd8,  7'd16, 7'd32}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic count64(output int c, output int x, output int h);
    c = 0; x = 0; h = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); c += cpu_ce; x += axi_ce; h += ahb_ce;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c, x, h, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h08, d); check("R1 div reset", d, 32'h10);
    rd(8'h84, d); check("R1 gate reset", d, 32'h0080_0001);
    rd(8'h88, d); check("R1 rst reset", d, 32'h3F7D_FFFE);
    check("R1 run reset", {2'b0, run_o}, 32'h0080_0001);

    for (int k = 0; k < NV; k++) begin
      wr(8'h08, {26'h3FF_FFC0 & 26'h0, VEC[k][32:27]});
      rd(8'h08, d); check("R2 R4 readback", d, {26'h0, VEC[k][26:21]});
      repeat (16) @(negedge clk);
      count64(c, x, h);
      check("R3 R4 cpu strobes", c, VEC[k][20:14]);
      check("R3 axi strobes", x, VEC[k][13:7]);
      check("R3 R4 ahb strobes", h, VEC[k][6:0]);
    end

    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R2 upper bits zero", d, 32'h3F);
    repeat (16) @(negedge clk);
    n = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); if (cpu_ce && axi_ce && ahb_ce) n++;
    end
    check("R5 joint strobes per frame", n, 8);

    // frame-boundary write: wait for last cycle of a frame, then request /1
    do @(negedge clk); while (!cpu_ce);
    wr_en = 1'b1; addr = 8'h08; wdata = 32'h30;
    @(negedge clk); wr_en = 1'b0;
    n = cpu_ce;
    for (int i = 0; i < 7; i++) begin @(negedge clk); n += cpu_ce; end
    check("R5 old ratio kept to frame end", n, 1);
    n = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); n += cpu_ce; end
    check("R5 new ratio after wrap", n, 8);

    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h84, d); check("R6 R7 gate write", d, 32'h3FFD_FFFF);
    wr(8'h88, 32'h0);
    rd(8'h88, d); check("R6 rst write", d, 32'h0);
    check("R8 all running", {2'b0, run_o}, 32'h3FFD_FFFF);
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h88, d); check("R7 rst reserved", d, 32'h3FFD_FFFF);
    check("R8 none running", {2'b0, run_o}, 32'h0);
    wr(8'h88, 32'h0000_0F0F);
    wr(8'h84, 32'h0000_00FF);
    check("R8 mixed run", {2'b0, run_o}, 32'h0000_00F0);
    check("R6 gate port", {2'b0, gate_o}, 32'h0000_00FF);

    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R9 unmapped read", d, 32'h0);
    rd(8'h80, d); check("R9 unmapped read 0x80", d, 32'h0);
    rd(8'h84, d); check("R9 gate untouched", d, 32'h0000_00FF);
    rd(8'h88, d); check("R9 rst untouched", d, 32'h0000_0F0F);
    rd(8'h08, d); check("R9 div untouched", d, 32'h30);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule